// File: doc/BRIEF.md
# Fair Bus Requester with Release Policy

This block sits between one local bus master and a shared backplane arbitration scheme. When the local master asks for the bus, the block raises the request line of the arbitration level it is configured for. It then waits for the grant that travels down a daisy chain. If the grant arrives while the block is requesting, the block keeps the grant, asserts bus-busy and hands ownership to the local master. If the grant arrives while the block is idle, the block passes it to the next module through grant-out.

Two policies decide when the bus is given back, and a mode field selects between them. Under release-when-done, bus-busy falls as soon as the local master reports it is finished. Under release-on-request, the block keeps the bus parked after the local master finishes. It gives the bus up only when some other module raises any request line, and it can hand the parked bus straight back to its own master without a new arbitration round.

An optional fairness setting stops the block from raising its request while the shared line of its own level is already asserted by another module. The pending local request is kept and tried again once that line goes idle. All pins are plain level signals sampled on the rising clock. None of them is a data stream, so there is no valid/ready handshake.

Top module: `fbr_requester`

## Requirements
- R1: While reset is asserted and right after it is released, req_line, grant_out, bus_busy and loc_grant are all low.
- R2: Mode bits [1:0] give the level L. When the block requests, only bit L of req_line is high and every other bit stays low.
- R3: With mode bit 3 = 0 (fairness off), loc_req high in the idle state raises req_line bit L on the next clock. Once raised, the request is held until a grant is taken.
- R4: With mode bit 3 = 1 (fairness on), an idle block raises its request only if req_in bit L was low at the deciding edge. Otherwise it stays idle, keeps the pending loc_req, and requests on the clock after it sees req_in bit L low.
- R5: When grant_in is high while the block is requesting, then on the next clock bus_busy and loc_grant are high and req_line is all zero. grant_out stays low.
- R6: When grant_in is high while the block is idle, grant_out is high on the next clock. In every other state grant_out is low.
- R7: With mode bit 2 = 0 (release-when-done), loc_done sampled while loc_grant is high drops bus_busy and loc_grant on the next clock. bus_busy stays high until that happens.
- R8: With mode bit 2 = 1 (release-on-request), loc_done drops loc_grant on the next clock but bus_busy stays high (parked). While parked, any bit of req_in high releases the bus, with bus_busy low on the next clock.
- R9: While parked with all req_in bits low, loc_req high gives loc_grant back on the next clock, with no request raised.
- R10: In the clock where bus_busy falls, req_line is all zero. A new request can appear at the earliest one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | [1:0] level, [2] release-on-request, [3] fairness |
| loc_req | input | 1 | Local master wants the bus |
| loc_done | input | 1 | Local master has finished its transfers |
| req_in | input | 4 | Observed level of the shared request lines |
| grant_in | input | 1 | Grant arriving on the daisy chain |
| req_line | output | 4 | Request drive, one bit per level |
| grant_out | output | 1 | Grant passed down the daisy chain |
| bus_busy | output | 1 | The bus is held by this module |
| loc_grant | output | 1 | Local master may use the bus |

## Verification
The assertions assume that the mode field changes only while the block is idle. They also assume that the observed request lines reflect the other modules' drive sampled at the same edge as the block's own inputs. The fairness and release properties compare the current mode against past line values, so they rely on mode staying stable. The stimulus changes mode only after bus_busy and req_line have both been low for a clock. It drives every input on the falling edge. It asserts loc_done only while the local grant is present, and it raises other levels' lines only to provoke parked releases and fairness hold-off.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_PARK = 2'd3
  } fbr_state_e;
endpackage

// File: rtl/fbr_line_watch.sv
module fbr_line_watch #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic [NUM_LEVELS-1:0] req_in,
  input  logic [LVL_W-1:0]      level,
  output logic                  own_line_up,
  output logic                  any_line_up
);
  logic [NUM_LEVELS-1:0] hit;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_sel
    assign hit[g] = req_in[g] && (level == LVL_W'(g));
  end

  assign own_line_up = |hit;
  assign any_line_up = |req_in;
endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fair_en,
  input  logic       ror_en,
  input  logic       loc_req,
  input  logic       loc_done,
  input  logic       own_line_up,
  input  logic       any_line_up,
  input  logic       grant_in,
  output fbr_state_e state
);
  fbr_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (loc_req && !(fair_en && own_line_up)) nxt = ST_ASK;
      ST_ASK:  if (grant_in) nxt = ST_OWN;
      ST_OWN:  if (loc_done) nxt = ror_en ? ST_PARK : ST_IDLE;
      ST_PARK: begin
        if (any_line_up)  nxt = ST_IDLE;
        else if (loc_req) nxt = ST_OWN;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/fbr_line_drive.sv
module fbr_line_drive #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  asking,
  input  logic [LVL_W-1:0]      level,
  output logic [NUM_LEVELS-1:0] req_line
);
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_drv
    assign req_line[g] = asking && (level == LVL_W'(g));
  end
endmodule

// File: rtl/fbr_chain.sv
module fbr_chain (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic grant_in,
  output logic grant_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_out <= 1'b0;
    else        grant_out <= grant_in && idle;
  end
endmodule

// File: rtl/fbr_requester.sv
module fbr_requester
  import fbr_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W  = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int MODE_W = LVL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MODE_W-1:0]     mode,
  input  logic                  loc_req,
  input  logic                  loc_done,
  input  logic [NUM_LEVELS-1:0] req_in,
  input  logic                  grant_in,
  output logic [NUM_LEVELS-1:0] req_line,
  output logic                  grant_out,
  output logic                  bus_busy,
  output logic                  loc_grant
);
  logic [LVL_W-1:0] level;
  logic             ror_en, fair_en;
  logic             own_line_up, any_line_up;
  fbr_state_e       state;

  assign level   = mode[LVL_W-1:0];
  assign ror_en  = mode[LVL_W];
  assign fair_en = mode[LVL_W+1];

  fbr_line_watch #(.NUM_LEVELS(NUM_LEVELS)) u_watch (
    .req_in(req_in), .level(level),
    .own_line_up(own_line_up), .any_line_up(any_line_up)
  );

  fbr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fair_en(fair_en), .ror_en(ror_en),
    .loc_req(loc_req), .loc_done(loc_done),
    .own_line_up(own_line_up), .any_line_up(any_line_up),
    .grant_in(grant_in), .state(state)
  );

  fbr_line_drive #(.NUM_LEVELS(NUM_LEVELS)) u_drive (
    .asking(state == ST_ASK), .level(level), .req_line(req_line)
  );

  fbr_chain u_chain (
    .clk(clk), .rst_n(rst_n), .idle(state == ST_IDLE),
    .grant_in(grant_in), .grant_out(grant_out)
  );

  assign bus_busy  = (state == ST_OWN) || (state == ST_PARK);
  assign loc_grant = (state == ST_OWN);
endmodule

// File: rtl/fbr_requester_chk.sv
module fbr_requester_chk #(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W  = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int MODE_W = LVL_W + 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [MODE_W-1:0]     mode,
  input logic                  loc_req,
  input logic                  loc_done,
  input logic [NUM_LEVELS-1:0] req_in,
  input logic                  grant_in,
  input logic [NUM_LEVELS-1:0] req_line,
  input logic                  grant_out,
  input logic                  bus_busy,
  input logic                  loc_grant
);
  AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_line)); // R2

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_busy && (|req_line))); // R5

  AST_GRANT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_line) && grant_in) |=> (bus_busy && loc_grant && !grant_out)); // R5

  AST_IDLE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && !(|req_line) && grant_in) |=> grant_out); // R6

  AST_RWD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_grant && loc_done && !mode[LVL_W]) |=> !bus_busy); // R7

  AST_ROR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_grant && loc_done && mode[LVL_W]) |=> (bus_busy && !loc_grant)); // R8

  AST_NO_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> (req_line == '0)); // R10

  AST_FAIR_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|req_line) && mode[LVL_W+1]) |-> !$past(req_in[mode[LVL_W-1:0]])); // R4
endmodule

bind fbr_requester fbr_requester_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (.*);

// File: tb/test_fbr_requester.sv
module test_fbr_requester;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic       loc_req = 1'b0, loc_done = 1'b0, grant_in = 1'b0;
  logic [3:0] req_in = 4'd0;
  logic [3:0] req_line;
  logic       grant_out, bus_busy, loc_grant;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done_flag = 0;

  // reference model: 0 idle, 1 asking, 2 owning, 3 parked
  int ms = 0;
  bit mg = 0;

  always #4 clk = ~clk;

  fbr_requester i_fbr_requester (
    .clk(clk), .rst_n(rst_n), .mode(mode), .loc_req(loc_req),
    .loc_done(loc_done), .req_in(req_in), .grant_in(grant_in),
    .req_line(req_line), .grant_out(grant_out), .bus_busy(bus_busy),
    .loc_grant(loc_grant)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mg = 0;
    end else begin
      mg = grant_in && (ms == 0);
      case (ms)
        0: if (loc_req && !(mode[3] && req_in[mode[1:0]])) ms = 1;
        1: if (grant_in) ms = 2;
        2: if (loc_done) ms = mode[2] ? 3 : 0;
        3: if (req_in != 0) ms = 0; else if (loc_req) ms = 2;
        default: ms = 0;
      endcase
    end
  end

  task automatic check1(string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check1("req_line", req_line, (ms == 1) ? (4'd1 << mode[1:0]) : 4'd0);
    check1("grant_out", {3'd0, grant_out}, {3'd0, mg});
    check1("bus_busy", {3'd0, bus_busy}, {3'd0, (ms >= 2)});
    check1("loc_grant", {3'd0, loc_grant}, {3'd0, (ms == 2)});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    run(3);
    rst_n = 1'b1;
    run(2);

    // R2 R3: non-fair request on level 2, held until grant
    tag = "R3"; mode = 4'b0010;
    loc_req = 1;
    run(4);
    tag = "R5"; grant_in = 1; tick(); grant_in = 0;
    run(2);
    // R7: release-when-done
    tag = "R7"; loc_done = 1; tick(); loc_done = 0;
    // R10: immediate re-request not in release clock
    tag = "R10"; run(3);
    grant_in = 1; tick(); grant_in = 0;
    loc_req = 0; loc_done = 1; tick(); loc_done = 0;
    run(2);

    // R6: pass-through while idle
    tag = "R6";
    grant_in = 1; run(3); grant_in = 0; run(2);

    // R2: other levels
    tag = "R2"; mode = 4'b0000; loc_req = 1; run(2);
    grant_in = 1; tick(); grant_in = 0; loc_req = 0;
    loc_done = 1; tick(); loc_done = 0; run(2);
    mode = 4'b0011; loc_req = 1; run(2);
    grant_in = 1; tick(); grant_in = 0; loc_req = 0;
    loc_done = 1; tick(); loc_done = 0; run(2);

    // R4: fairness hold-off on level 1
    tag = "R4"; mode = 4'b1001;
    req_in = 4'b0010; loc_req = 1; run(5);
    req_in = 4'b0100; run(2);          // other level up does not block
    grant_in = 1; tick(); grant_in = 0; loc_req = 0; req_in = 0;
    loc_done = 1; tick(); loc_done = 0; run(2);
    req_in = 4'b0010; run(1); loc_req = 1; run(3);
    req_in = 4'b0000; run(2);
    grant_in = 1; tick(); grant_in = 0; loc_req = 0;
    loc_done = 1; tick(); loc_done = 0; run(2);

    // R8 R9: release-on-request on level 3
    tag = "R8"; mode = 4'b0111; loc_req = 1; run(2);
    grant_in = 1; tick(); grant_in = 0; loc_req = 0;
    run(2);
    loc_done = 1; tick(); loc_done = 0;
    grant_in = 1; run(3); grant_in = 0;   // parked: grant not forwarded
    tag = "R9"; loc_req = 1; tick(); loc_req = 0; run(2);
    loc_done = 1; tick(); loc_done = 0; run(2);
    tag = "R8"; loc_req = 1; req_in = 4'b0001; tick(); req_in = 0;
    tag = "R10"; run(4);
    grant_in = 1; tick(); grant_in = 0; loc_req = 0;
    loc_done = 1; tick(); loc_done = 0; run(3);
    tag = "R8"; req_in = 4'b1000; tick(); req_in = 0; run(3);

    // R1: reset again in the middle of ownership
    tag = "R1"; mode = 4'b0001; loc_req = 1; run(2);
    grant_in = 1; tick(); grant_in = 0;
    rst_n = 0; loc_req = 0; run(2); rst_n = 1; run(2);

    finish_up();
  end
endmodule